// File: doc/BRIEF.md
# Controller Command Dispatcher with Seconds Clock

This block sits behind the byte link of a system-management controller. Once a host packet has been received, it is decoded here: the first byte names the packet type, and for controller packets the second byte is a command code. The command code selects one of a fixed set of handlers. Each handler checks how many argument bytes it was given, acts on the block's state, and returns a reply packet. The reply leaves the block one byte per cycle.

The block holds four pieces of state. The first is a 32-bit seconds clock that counts from midnight, 1 January 1904. The second is a flag that enables autopolling, and the third is the autopoll period in milliseconds. The fourth is a 16-bit mask that selects which peripherals get polled. While autopolling is on, a period timer raises a one-cycle poll request. Power-down and system-reset commands each produce a one-cycle request pulse. The peripheral transactions themselves belong to other logic, which reads the mask and the poll request from this block.

Top module: `cmd_dispatch_rtc`

## Requirements
- R1: After reset:
  - no reply is being sent;
  - `poll_mask` is 0xFFFF;
  - autopoll is off;
  - both request pulses are low;
  - the seconds clock reads `RTC_RESET` (0 by default);
  - the autopoll period is `DEFAULT_RATE` ms (20).
- R2: A command that succeeds replies with the type byte 0x01 (controller), then the status 0x00, then the command code, followed by the handler's output bytes. The reply bytes appear one per cycle with `out_valid` high, and `out_last` is high on the final byte.
- R3: An unrecognised command code replies {0x02, 0x02, 0x01, command}, and no state changes. The recognised codes are 0x01, 0x03, 0x09, 0x0A, 0x11, 0x13, 0x14, 0x19 and 0x21.
- R4: If the number of argument bytes is wrong, the reply is {0x02, 0x05, 0x01, command} and the command has no effect. Each command expects the following count:
  - autopoll 0x01: 1;
  - get time 0x03: 0;
  - set time 0x09: 4;
  - power down 0x0A: 0;
  - reset 0x11: 0;
  - file-server flag 0x13: 1;
  - set rate 0x14: 1;
  - device list 0x19: 2;
  - power messages 0x21: 1.
- R5: Get time (0x03) returns the seconds clock as four payload bytes, most significant byte first.
- R6: Set time (0x09) loads the seconds clock from its four argument bytes, first byte most significant. The clock then advances by one every `CLK_PER_MS*1000` cycles and wraps from 0xFFFFFFFF to 0.
- R7: Set rate (0x14) takes the period in ms from its one argument byte. An argument of 0 gets the bad-argument error reply and leaves the period unchanged.
- R8: Device list (0x19) sets `poll_mask` from two argument bytes, the first byte being the high byte.
- R9: Autopoll (0x01) turns polling on when its argument is nonzero and off when it is zero. While polling is on, `poll_req` pulses once every rate×`CLK_PER_MS` cycles, and changing the rate restarts the period. While polling is off, `poll_req` stays low.
- R10: Power down (0x0A) and reset system (0x11) each raise their request output (`power_down_req` and `reset_req` respectively) for exactly one cycle. They do so only when the argument count is correct.
- R11: A packet whose type byte is not 0x01, or that ends before a command byte, produces no reply and changes no state.
- R12: The file-server flag (0x13) and power-messages (0x21) commands each take one argument byte. They reply with an empty payload and change no state.
- R13: Bytes that arrive while a packet is being executed or a reply is being sent are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Packet byte present |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Final byte of the packet |
| out_valid | output | 1 | Reply byte present |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final reply byte |
| poll_req | output | 1 | One-cycle autopoll request |
| autopoll_on | output | 1 | Autopoll enabled |
| poll_mask | output | 16 | Peripheral poll mask |
| power_down_req | output | 1 | One-cycle power-down request |
| reset_req | output | 1 | One-cycle system-reset request |

## Verification
The bench builds the block with `CLK_PER_MS` set to 4. At that setting one second is 4000 cycles, so the bench can load the seconds clock with 0xFFFFFFFF, watch it wrap to zero, and still finish in a few thousand cycles. The same setting makes the default 20 ms autopoll period 80 cycles and a 3 ms period 12 cycles. The bench measures both periods exactly from the gap between consecutive poll pulses.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
    localparam int BYTE_W      = 8;
    localparam int ARG_BYTES   = 4;
    localparam int ARG_W       = ARG_BYTES * BYTE_W;
    localparam int HDR_BYTES   = 3;
    localparam int REPLY_BYTES = HDR_BYTES + ARG_BYTES;
    localparam int REPLY_W     = REPLY_BYTES * BYTE_W;
    localparam int CNT_W       = 3;

    localparam logic [7:0] PT_PERIPH = 8'h00;
    localparam logic [7:0] PT_CTRL   = 8'h01;
    localparam logic [7:0] PT_ERROR  = 8'h02;

    localparam logic [7:0] ST_OK       = 8'h00;
    localparam logic [7:0] ERR_UNKNOWN = 8'h02;
    localparam logic [7:0] ERR_BADARG  = 8'h05;

    localparam logic [7:0] OP_AUTOPOLL  = 8'h01;
    localparam logic [7:0] OP_GET_TIME  = 8'h03;
    localparam logic [7:0] OP_SET_TIME  = 8'h09;
    localparam logic [7:0] OP_POWER_OFF = 8'h0A;
    localparam logic [7:0] OP_RESET_SYS = 8'h11;
    localparam logic [7:0] OP_FS_FLAG   = 8'h13;
    localparam logic [7:0] OP_SET_RATE  = 8'h14;
    localparam logic [7:0] OP_DEV_LIST  = 8'h19;
    localparam logic [7:0] OP_PWR_MSGS  = 8'h21;

    typedef enum logic [1:0] {PH_RX, PH_EXEC, PH_TX} phase_e;

    typedef struct packed {
        logic             known;
        logic             args_ok;
        logic             set_auto;
        logic             auto_val;
        logic             set_rate;
        logic [7:0]       rate;
        logic             set_mask;
        logic [15:0]      mask;
        logic             set_time;
        logic [ARG_W-1:0] time_val;
        logic             get_time;
        logic             pwr;
        logic             rst;
    } decision_t;
endpackage

// File: rtl/cmdp_decode.sv
module cmdp_decode
    import cmdp_pkg::*;
(
    input  logic [7:0]       cmd_i,
    input  logic [CNT_W-1:0] nargs_i,
    input  logic [ARG_W-1:0] args_i,
    output decision_t        dec_o
);
    logic [7:0] first;
    assign first = args_i[ARG_W-1 -: 8];

    always_comb begin
        dec_o       = '0;
        dec_o.known = 1'b1;
        unique case (cmd_i)
            OP_AUTOPOLL: begin
                dec_o.args_ok  = (nargs_i == 3'd1);
                dec_o.set_auto = dec_o.args_ok;
                dec_o.auto_val = (first != 8'h00);
            end
            OP_GET_TIME: begin
                dec_o.args_ok  = (nargs_i == 3'd0);
                dec_o.get_time = dec_o.args_ok;
            end
            OP_SET_TIME: begin
                dec_o.args_ok  = (nargs_i == 3'd4);
                dec_o.set_time = dec_o.args_ok;
                dec_o.time_val = args_i;
            end
            OP_POWER_OFF: begin
                dec_o.args_ok = (nargs_i == 3'd0);
                dec_o.pwr     = dec_o.args_ok;
            end
            OP_RESET_SYS: begin
                dec_o.args_ok = (nargs_i == 3'd0);
                dec_o.rst     = dec_o.args_ok;
            end
            OP_FS_FLAG, OP_PWR_MSGS: begin
                dec_o.args_ok = (nargs_i == 3'd1);
            end
            OP_SET_RATE: begin
                dec_o.args_ok  = (nargs_i == 3'd1) && (first != 8'h00);
                dec_o.set_rate = dec_o.args_ok;
                dec_o.rate     = first;
            end
            OP_DEV_LIST: begin
                dec_o.args_ok  = (nargs_i == 3'd2);
                dec_o.set_mask = dec_o.args_ok;
                dec_o.mask     = args_i[ARG_W-1 -: 16];
            end
            default: dec_o.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmdp_rtc.sv
module cmdp_rtc #(
    parameter int          TICKS_PER_SEC = 50_000_000,
    parameter logic [31:0] RESET_SECS    = 32'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [31:0] load_val_i,
    output logic [31:0] secs_o
);
    localparam int SUB_W = $clog2(TICKS_PER_SEC + 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SEC - 1);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [31:0]      secs;
    } rtc_t;

    rtc_t rtc_d, rtc_q;

    always_comb begin
        rtc_d = rtc_q;
        if (load_i) begin
            rtc_d.sub  = '0;
            rtc_d.secs = load_val_i;
        end else if (rtc_q.sub == SUB_LAST) begin
            rtc_d.sub  = '0;
            rtc_d.secs = rtc_q.secs + 32'd1;
        end else begin
            rtc_d.sub = rtc_q.sub + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rtc_q.sub  <= '0;
            rtc_q.secs <= RESET_SECS;
        end else begin
            rtc_q <= rtc_d;
        end
    end

    assign secs_o = rtc_q.secs;

    // R6: without a load the clock holds or steps by exactly one
    a_r6_rtc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) |-> (secs_o == $past(secs_o)) || (secs_o == $past(secs_o) + 32'd1));
    // R6: a load takes effect on the next edge
    a_r6_rtc_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> secs_o == $past(load_val_i));
endmodule

// File: rtl/cmdp_poll_timer.sv
module cmdp_poll_timer #(
    parameter int CLK_PER_MS = 50_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       restart_i,
    input  logic [7:0] rate_i,
    output logic       poll_o
);
    localparam int PRE_W = $clog2(CLK_PER_MS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [7:0]       ms;
        logic             pulse;
    } ptmr_t;

    ptmr_t t_d, t_q;

    always_comb begin
        t_d       = t_q;
        t_d.pulse = 1'b0;
        if (restart_i || !enable_i) begin
            t_d.pre = '0;
            t_d.ms  = '0;
        end else if (t_q.pre == PRE_LAST) begin
            t_d.pre = '0;
            if (t_q.ms == rate_i - 8'd1) begin
                t_d.ms    = '0;
                t_d.pulse = 1'b1;
            end else begin
                t_d.ms = t_q.ms + 8'd1;
            end
        end else begin
            t_d.pre = t_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign poll_o = t_q.pulse;

    // R9: a poll request only follows a cycle in which polling was enabled
    a_r9_poll_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        poll_o |-> $past(enable_i));
    // R9: a poll request is a single-cycle pulse
    a_r9_poll_single: assert property (@(posedge clk) disable iff (!rst_n)
        poll_o |=> !poll_o);
endmodule

// File: rtl/cmd_dispatch_rtc.sv
module cmd_dispatch_rtc
    import cmdp_pkg::*;
#(
    parameter int          CLK_PER_MS   = 50_000,
    parameter logic [31:0] RTC_RESET    = 32'd0,
    parameter logic [7:0]  DEFAULT_RATE = 8'd20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        poll_req,
    output logic        autopoll_on,
    output logic [15:0] poll_mask,
    output logic        power_down_req,
    output logic        reset_req
);
    localparam int MS_PER_SEC    = 1000;
    localparam int TICKS_PER_SEC = CLK_PER_MS * MS_PER_SEC;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   rx_cnt;
        logic [7:0]         ptype;
        logic [7:0]         cmd;
        logic [ARG_W-1:0]   args;
        logic [REPLY_W-1:0] reply;
        logic [CNT_W-1:0]   tx_len;
        logic [CNT_W-1:0]   tx_idx;
        logic               auto_en;
        logic [7:0]         rate;
        logic [15:0]        mask;
        logic               pwr;
        logic               rst;
    } state_t;

    state_t             s_d, s_q;
    decision_t          dec;
    logic [CNT_W-1:0]   nargs;
    logic               rtc_load;
    logic [31:0]        rtc_secs;
    logic               poll_restart;
    logic [REPLY_W-1:0] reply_sh;

    assign nargs = (s_q.rx_cnt >= 3'd2) ? s_q.rx_cnt - 3'd2 : 3'd0;

    cmdp_decode u_decode (
        .cmd_i  (s_q.cmd),
        .nargs_i(nargs),
        .args_i (s_q.args),
        .dec_o  (dec)
    );

    cmdp_rtc #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .RESET_SECS   (RTC_RESET)
    ) u_rtc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (rtc_load),
        .load_val_i(dec.time_val),
        .secs_o    (rtc_secs)
    );

    cmdp_poll_timer #(
        .CLK_PER_MS(CLK_PER_MS)
    ) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (s_q.auto_en),
        .restart_i(poll_restart),
        .rate_i   (s_q.rate),
        .poll_o   (poll_req)
    );

    always_comb begin
        s_d          = s_q;
        s_d.pwr      = 1'b0;
        s_d.rst      = 1'b0;
        rtc_load     = 1'b0;
        poll_restart = 1'b0;
        unique case (s_q.phase)
            PH_RX: begin
                if (in_valid) begin
                    unique case (s_q.rx_cnt)
                        3'd0: s_d.ptype = in_data;
                        3'd1: s_d.cmd = in_data;
                        3'd2: s_d.args[31:24] = in_data;
                        3'd3: s_d.args[23:16] = in_data;
                        3'd4: s_d.args[15:8] = in_data;
                        3'd5: s_d.args[7:0] = in_data;
                        default: ;
                    endcase
                    if (s_q.rx_cnt != 3'd7) s_d.rx_cnt = s_q.rx_cnt + 3'd1;
                    if (in_last) s_d.phase = PH_EXEC;
                end
            end
            PH_EXEC: begin
                s_d.phase  = PH_RX;
                s_d.rx_cnt = '0;
                s_d.args   = '0;
                s_d.tx_idx = '0;
                if (s_q.ptype == PT_CTRL && s_q.rx_cnt >= 3'd2) begin
                    s_d.phase = PH_TX;
                    if (!dec.known) begin
                        s_d.reply  = {PT_ERROR, ERR_UNKNOWN, PT_CTRL, s_q.cmd, 24'h0};
                        s_d.tx_len = 3'd4;
                    end else if (!dec.args_ok) begin
                        s_d.reply  = {PT_ERROR, ERR_BADARG, PT_CTRL, s_q.cmd, 24'h0};
                        s_d.tx_len = 3'd4;
                    end else begin
                        s_d.reply  = {PT_CTRL, ST_OK, s_q.cmd,
                                      dec.get_time ? rtc_secs : 32'h0};
                        s_d.tx_len = dec.get_time ? 3'(REPLY_BYTES) : 3'(HDR_BYTES);
                        if (dec.set_auto) begin
                            s_d.auto_en  = dec.auto_val;
                            poll_restart = dec.auto_val && !s_q.auto_en;
                        end
                        if (dec.set_rate) begin
                            s_d.rate     = dec.rate;
                            poll_restart = s_q.auto_en;
                        end
                        if (dec.set_mask) s_d.mask = dec.mask;
                        rtc_load = dec.set_time;
                        s_d.pwr  = dec.pwr;
                        s_d.rst  = dec.rst;
                    end
                end
            end
            PH_TX: begin
                s_d.tx_idx = s_q.tx_idx + 3'd1;
                if (s_q.tx_idx == s_q.tx_len - 3'd1) s_d.phase = PH_RX;
            end
            default: s_d.phase = PH_RX;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.phase   <= PH_RX;
            s_q.rate    <= DEFAULT_RATE;
            s_q.mask    <= 16'hFFFF;
        end else begin
            s_q <= s_d;
        end
    end

    assign reply_sh       = s_q.reply << {s_q.tx_idx, 3'b000};
    assign out_valid      = (s_q.phase == PH_TX);
    assign out_data       = out_valid ? reply_sh[REPLY_W-1 -: 8] : 8'h00;
    assign out_last       = out_valid && (s_q.tx_idx == s_q.tx_len - 3'd1);
    assign autopoll_on    = s_q.auto_en;
    assign poll_mask      = s_q.mask;
    assign power_down_req = s_q.pwr;
    assign reset_req      = s_q.rst;

    // R10: request outputs last exactly one cycle
    a_r10_pwr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        power_down_req |=> !power_down_req);
    a_r10_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);
    // R7: the period register never holds zero
    a_r7_rate_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rate != 8'd0);
    // R2: a reply is at least a header and ends after its last byte
    a_r2_reply_len: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> s_q.tx_len >= 3'd3);
    a_r2_reply_ends: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);
    // R13: a reply starts only right after a packet was executed
    a_r13_tx_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(s_q.phase) == PH_EXEC);
endmodule

// File: tb/cmd_dispatch_rtc_bench.sv
module cmd_dispatch_rtc_bench;
    localparam int CPM = 4;
    localparam int SEC = CPM * 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        out_valid, out_last, poll_req, autopoll_on;
    logic        power_down_req, reset_req;
    logic [7:0]  out_data;
    logic [15:0] poll_mask;

    always #5 clk = ~clk;

    cmd_dispatch_rtc #(.CLK_PER_MS(CPM)) u_cmd_dispatch_rtc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .poll_req(poll_req), .autopoll_on(autopoll_on),
        .poll_mask(poll_mask), .power_down_req(power_down_req),
        .reset_req(reset_req)
    );

    int n_chk = 0;
    int n_bad = 0;

    // monitors, all sampling at the falling edge
    int         cyc = 0;
    int         cap_n = 0;
    int         cap_total = 0;
    logic [7:0] cap [16];
    int         poll_cnt = 0, poll_last = 0, poll_gap = 0;
    int         pwr_cnt = 0, rst_cnt = 0;
    int         cap_base = 0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (out_valid) begin
            if (cap_total - cap_base < 16) cap[cap_total - cap_base] = out_data;
            cap_total = cap_total + 1;
        end
        if (poll_req) begin
            poll_gap  = cyc - poll_last;
            poll_last = cyc;
            poll_cnt  = poll_cnt + 1;
        end
        if (power_down_req) pwr_cnt = pwr_cnt + 1;
        if (reset_req) rst_cnt = rst_cnt + 1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input int len, input logic [47:0] bytes);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = bytes[47 - 8*i -: 8];
            in_last  = (i == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    // send a packet and gather its reply as {count, left-aligned bytes}
    task automatic xfer(input int len, input logic [47:0] bytes, output logic [63:0] rep);
        logic [55:0] w;
        int n;
        cap_base = cap_total;
        send(len, bytes);
        repeat (20) @(negedge clk);
        n = cap_total - cap_base;
        w = '0;
        for (int i = 0; i < 7; i++) if (i < n) w[55 - 8*i -: 8] = cap[i];
        rep = {5'd0, 3'(n), w};
    endtask

    typedef struct packed {
        logic [3:0]  tag;
        logic [2:0]  ilen;
        logic [47:0] ib;
        logic [2:0]  olen;
        logic [55:0] ob;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd12, 3'd3, 48'h011305000000, 3'd3, 56'h01001300000000}, // R12 file-server flag
        '{4'd12, 3'd3, 48'h012100000000, 3'd3, 56'h01002100000000}, // R12 power messages
        '{4'd3,  3'd2, 48'h017700000000, 3'd4, 56'h02020177000000}, // R3 unknown code
        '{4'd4,  3'd2, 48'h011300000000, 3'd4, 56'h02050113000000}, // R4 missing argument
        '{4'd8,  3'd4, 48'h011912340000, 3'd3, 56'h01001900000000}, // R8 device list
        '{4'd7,  3'd3, 48'h011400000000, 3'd4, 56'h02050114000000}, // R7 zero rate rejected
        '{4'd6,  3'd6, 48'h010912345678, 3'd3, 56'h01000900000000}, // R6 set time
        '{4'd5,  3'd2, 48'h010300000000, 3'd7, 56'h01000312345678}, // R5 get time big-endian
        '{4'd4,  3'd3, 48'h010A01000000, 3'd4, 56'h0205010A000000}, // R4 power down with arg
        '{4'd4,  3'd3, 48'h010300000000, 3'd4, 56'h02050103000000}, // R4 get time with arg
        '{4'd3,  3'd2, 48'h010000000000, 3'd4, 56'h02020100000000}, // R3 code 0x00 unknown
        '{4'd10, 3'd2, 48'h010A00000000, 3'd3, 56'h01000A00000000}, // R10 power down
        '{4'd10, 3'd2, 48'h011100000000, 3'd3, 56'h01001100000000}  // R10 reset system
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] rep;
        int snap, snap2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 poll_mask", 64'(poll_mask), 64'hFFFF);
        chk("R1 autopoll_on", 64'(autopoll_on), 64'd0);
        chk("R1 requests", 64'({power_down_req, reset_req}), 64'd0);
        xfer(2, 48'h010300000000, rep);
        chk("R1 seconds at reset", rep, {8'd7, 56'h01000300000000});

        // R1/R9 default period with autopoll enabled
        xfer(3, 48'h010101000000, rep);
        chk("R9 enable reply", rep, {8'd3, 56'h01000100000000});
        chk("R9 autopoll_on", 64'(autopoll_on), 64'd1);
        snap = poll_cnt;
        repeat (250) @(negedge clk);
        chk("R9 pulses seen", 64'(poll_cnt - snap >= 2), 64'd1);
        chk("R1 default period", 64'(poll_gap), 64'(20 * CPM));

        // R9 rate change restarts with new period
        xfer(3, 48'h011403000000, rep);
        repeat (100) @(negedge clk);
        chk("R9 period rate 3", 64'(poll_gap), 64'(3 * CPM));
        // R7 zero rejected, period unchanged
        xfer(3, 48'h011400000000, rep);
        chk("R7 zero rate reply", rep, {8'd4, 56'h02050114000000});
        repeat (100) @(negedge clk);
        chk("R7 period kept", 64'(poll_gap), 64'(3 * CPM));

        // R9 disable
        xfer(3, 48'h010100000000, rep);
        chk("R9 autopoll off", 64'(autopoll_on), 64'd0);
        snap = poll_cnt;
        repeat (200) @(negedge clk);
        chk("R9 no pulses when off", 64'(poll_cnt - snap), 64'd0);

        // table walk
        snap  = pwr_cnt;
        snap2 = rst_cnt;
        for (int i = 0; i < NV; i++) begin
            xfer(int'(VECS[i].ilen), VECS[i].ib, rep);
            chk($sformatf("R%0d vector %0d", VECS[i].tag, i), rep,
                {5'd0, VECS[i].olen, VECS[i].ob});
        end
        chk("R8 mask high byte first", 64'(poll_mask), 64'h1234);
        chk("R10 one power pulse cycle", 64'(pwr_cnt - snap), 64'd1);
        chk("R10 one reset pulse cycle", 64'(rst_cnt - snap2), 64'd1);

        // R11 non-controller and short packets
        snap = pwr_cnt;
        xfer(3, 48'h000A00000000, rep);
        chk("R11 peripheral type no reply", rep, 64'd0);
        xfer(1, 48'h010000000000, rep);
        chk("R11 short packet no reply", rep, 64'd0);
        chk("R11 no action", 64'(pwr_cnt - snap), 64'd0);

        // R13 bytes during execution and reply are ignored
        snap = rst_cnt;
        cap_base = cap_total;
        send(2, 48'h010300000000);
        // send() already spent the cycle after the last byte; drive during TX
        @(negedge clk); in_valid = 1'b1; in_data = 8'h01; in_last = 1'b0;
        @(negedge clk); in_valid = 1'b1; in_data = 8'h11; in_last = 1'b1;
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
        repeat (30) @(negedge clk);
        chk("R13 single reply", 64'(cap_total - cap_base), 64'd7);
        chk("R13 no reset pulse", 64'(rst_cnt - snap), 64'd0);

        // R6 wrap of the seconds clock
        xfer(6, 48'h0109FFFFFFFF, rep);
        chk("R6 set max reply", rep, {8'd3, 56'h01000900000000});
        repeat (SEC + SEC / 2) @(negedge clk);
        xfer(2, 48'h010300000000, rep);
        chk("R6 wrap to zero", rep, {8'd7, 56'h01000300000000});
        repeat (SEC) @(negedge clk);
        xfer(2, 48'h010300000000, rep);
        chk("R6 one more second", rep, {8'd7, 56'h01000300000001});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule